// File: doc/BRIEF.md
# Byte-Wide SPI Master With Sequenced Flag Clearing

This block is a register-mapped serial master. A host reaches it through a byte-wide bus with three registers. A rate register picks the serial clock speed. A status register reports a completion flag and a write-collision flag. A data register starts a transfer when written and returns the last received byte when read. Each transfer moves one byte out on MOSI, most significant bit first, and takes one byte in from MISO at the same time. SCK is low when idle. MOSI changes only on the falling edge of SCK, and MISO is sampled on the rising edge.

The serial clock is the system clock divided by a power of two, chosen by a 3-bit code. When the eighth SCK cycle ends, the completion flag rises. If the interrupt enable input is high, the interrupt output rises with it. The flags do not clear when they are read. The host must read the status register while a flag is set, and then read or write the data register. A data write during a transfer is ignored, and the write-collision flag records it.

Top module: `spi_byte_master`

## Requirements
- R1: The rate register is at address 0. It resets to 0 and can be read and written at any time. Only bits [2:0] are stored, and bits [7:3] read as 0.
- R2: For rate code r, SCK has a period of 2^(r+1) system clocks. Codes 0 to 7 give divisors 2 to 256. The completion flag becomes visible exactly 8·2^(r+1) clocks after the clock edge that takes the starting data write.
- R3: SCK is low whenever no transfer runs. MOSI sends the written byte MSB first, and it holds steady while SCK is high.
- R4: After a transfer, a read of the data register (address 2) returns the 8 bits sampled from MISO on the rising SCK edges, first bit in bit 7.
- R5: The status register is at address 1. The completion flag is bit 7 and the write-collision flag is bit 6. Every other bit reads 0. The completion flag sets after the eighth SCK cycle.
- R6: The flags clear only after two bus accesses in order: a status read that sees a flag set, then any read or write of the data register. Accesses to the rate register in between do not cancel this sequence. A data access without the earlier status read leaves the flags set.
- R7: Writes to the status register have no effect.
- R8: A data write while a transfer runs sets the write-collision flag. It changes neither the bits being sent nor the bits being received. The same two-access sequence clears the flag.
- R9: A data write while idle loads the byte and starts a transfer.
- R10: irq equals the completion flag ANDed with irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 rate, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle: SCK stays low when idle, MOSI holds while SCK is high, the completion flag follows the end of the eighth SCK cycle, a data write during a transfer raises the collision flag, and a flag can only fall on a data-register access. Other behaviour shows only across whole bench scenarios. These are the exact transfer length for each rate code, the byte order on both serial lines, and the order dependence of the clearing sequence, including a data access made without the status read and rate accesses placed between the two steps.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned RATE_W = 3;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_RATE = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned STAT_DONE_BIT = 7;
    localparam int unsigned STAT_COLL_BIT = 6;
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int unsigned RATE_W = spi_pkg::RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int unsigned CW = (1 << RATE_W) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = ~({CW{1'b1}} << rate);
        tick = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_tick_only_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int unsigned DW = spi_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] load_data,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic [DW-1:0] rx_data,
    output logic          done
);
    localparam int unsigned BCW = $clog2(DW);

    typedef struct packed {
        logic           busy;
        logic           sck;
        logic           samp;
        logic [BCW-1:0] bits;
        logic [DW-1:0]  sr;
        logic [DW-1:0]  rx;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.sck  = 1'b0;
                st_d.bits = '0;
                st_d.sr   = load_data;
            end
        end else if (tick) begin
            if (!st_q.sck) begin
                st_d.sck  = 1'b1;
                st_d.samp = miso;
            end else begin
                st_d.sck  = 1'b0;
                st_d.sr   = {st_q.sr[DW-2:0], st_q.samp};
                st_d.bits = st_q.bits + 1'b1;
                if (st_q.bits == BCW'(DW-1)) begin
                    st_d.busy = 1'b0;
                    st_d.rx   = {st_q.sr[DW-2:0], st_q.samp};
                    done      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign sck     = st_q.sck;
    assign mosi    = st_q.sr[DW-1];
    assign rx_data = st_q.rx;

    p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    p_mosi_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));
    p_start_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !sck));
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic coll,
    input  logic stat_rd,
    input  logic data_acc,
    output logic cpl_flag,
    output logic coll_flag
);
    typedef struct packed {
        logic cpl;
        logic col;
        logic armed;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_rd) begin
            st_d.armed = st_q.cpl | st_q.col;
        end
        if (data_acc && st_q.armed) begin
            st_d.cpl   = 1'b0;
            st_d.col   = 1'b0;
            st_d.armed = 1'b0;
        end
        if (done) st_d.cpl = 1'b1;
        if (coll) st_d.col = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpl_flag  = st_q.cpl;
    assign coll_flag = st_q.col;

    p_done_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cpl_flag);
    p_cpl_fall_on_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpl_flag) |-> $past(data_acc));
    p_col_fall_on_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coll_flag) |-> $past(data_acc));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
    parameter int unsigned DW     = spi_pkg::DATA_W,
    parameter int unsigned RATE_W = spi_pkg::RATE_W,
    parameter int unsigned AW     = spi_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          irq_en,
    output logic          irq,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    import spi_pkg::*;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          hit_rate, hit_stat, hit_data;
    logic          busy, tick, done;
    logic          start, coll, stat_rd;
    logic          cpl_flag, coll_flag;
    logic [DW-1:0] rx_data;
    logic [DW-1:0] stat_word;

    always_comb begin
        hit_rate = bus_sel && (bus_addr == REG_RATE);
        hit_stat = bus_sel && (bus_addr == REG_STAT);
        hit_data = bus_sel && (bus_addr == REG_DATA);
        stat_rd  = hit_stat && !bus_wr;
        start    = hit_data && bus_wr && !busy;
        coll     = hit_data && bus_wr && busy;

        st_d = st_q;
        if (hit_rate && bus_wr) st_d.rate = bus_wdata[RATE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_DONE_BIT] = cpl_flag;
        stat_word[STAT_COLL_BIT] = coll_flag;
        case (bus_addr)
            REG_RATE: bus_rdata = {{(DW-RATE_W){1'b0}}, st_q.rate};
            REG_STAT: bus_rdata = stat_word;
            REG_DATA: bus_rdata = rx_data;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = cpl_flag & irq_en;

    spi_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .rate (st_q.rate),
        .tick (tick)
    );

    spi_shifter #(.DW(DW)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_data(bus_wdata),
        .tick     (tick),
        .miso     (miso),
        .busy     (busy),
        .sck      (sck),
        .mosi     (mosi),
        .rx_data  (rx_data),
        .done     (done)
    );

    spi_flag_ctrl u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .coll     (coll),
        .stat_rd  (stat_rd),
        .data_acc (hit_data),
        .cpl_flag (cpl_flag),
        .coll_flag(coll_flag)
    );

    p_busy_write_collides_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_data && bus_wr && busy) |=> coll_flag);
    p_status_write_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_stat && bus_wr && !done && !coll) |=> ($stable(cpl_flag) && $stable(coll_flag)));
    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_en = 1'b0;
    logic       irq, sck, mosi;
    logic [7:0] slv_sr = 8'h00;
    logic [7:0] mosi_cap = 8'h00;
    logic       miso;
    int         total = 0;
    int         bad = 0;
    logic [7:0] rd;
    int         n;

    always #2.5 clk = ~clk;

    spi_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_en(irq_en), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
    );

    assign miso = slv_sr[7];
    always @(posedge sck) mosi_cap = {mosi_cap[6:0], mosi};
    always @(negedge sck) slv_sr = {slv_sr[6:0], 1'b0};

    function automatic int exp_len(input int r);
        return 16 << r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       output logic [7:0] r);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1 r = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek_stat(output logic [7:0] r);
        bus_addr = 2'd1;
        #0.5 r = bus_rdata;
    endtask

    task automatic wait_flag(output int cnt);
        logic [7:0] s;
        cnt = 0;
        bus_addr = 2'd1;
        forever begin
            @(posedge clk);
            #2;
            cnt++;
            s = bus_rdata;
            if (s[7] || cnt > 5000) break;
        end
    endtask

    task automatic xfer(input int r, input logic [7:0] tx, input logic [7:0] sl,
                        input string tag);
        logic [7:0] t;
        int c;
        acc(1'b1, 2'd0, 8'(r), t);
        slv_sr = sl;
        acc(1'b1, 2'd2, tx, t);
        wait_flag(c);
        chk({tag, " R2 transfer length"}, c, exp_len(r));
        chk({tag, " R3 mosi byte"}, mosi_cap, tx);
        chk({tag, " R3 sck idle"}, sck, 0);
    endtask

    task automatic clear_and_read(input logic [7:0] sl, input string tag);
        logic [7:0] t;
        acc(1'b0, 2'd1, 8'h00, t);
        chk({tag, " R5 status word"}, t, 8'h80);
        acc(1'b0, 2'd2, 8'h00, t);
        chk({tag, " R4 received byte"}, t, sl);
        peek_stat(t);
        chk({tag, " R6 cleared"}, t, 8'h00);
    endtask

    initial begin
        #150000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] t;
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        peek_stat(t);
        chk("R5 reset status", t, 0);
        acc(1'b0, 2'd0, 8'h00, t);
        chk("R1 reset rate", t, 0);
        chk("R3 reset sck", sck, 0);
        chk("R10 reset irq", irq, 0);

        acc(1'b1, 2'd0, 8'hFD, t);
        acc(1'b0, 2'd0, 8'h00, t);
        chk("R1 rate readback", t, 8'h05);
        acc(1'b0, 2'd3, 8'h00, t);
        chk("R1 unused address", t, 0);

        // R9, R2 at reset rate and the slowest rate
        xfer(0, 8'hA5, 8'h3C, "dir0");
        clear_and_read(8'h3C, "dir0");
        xfer(7, 8'h81, 8'h7E, "dir7");

        // R10 irq gating
        irq_en = 1'b1; #1;
        chk("R10 irq on", irq, 1);
        irq_en = 1'b0; #1;
        chk("R10 irq masked", irq, 0);
        irq_en = 1'b1;

        // R7 status writes do nothing
        acc(1'b1, 2'd1, 8'h00, t);
        peek_stat(t);
        chk("R7 write keeps flag", t, 8'h80);

        // R6 data access alone does not clear
        acc(1'b0, 2'd2, 8'h00, t);
        peek_stat(t);
        chk("R6 data read alone", t, 8'h80);
        chk("R10 irq still on", irq, 1);

        // R6 armed sequence survives rate access
        acc(1'b0, 2'd1, 8'h00, t);
        acc(1'b1, 2'd0, 8'h02, t);
        acc(1'b0, 2'd0, 8'h00, t);
        acc(1'b0, 2'd2, 8'h00, t);
        chk("R4 slow byte", t, 8'h7E);
        peek_stat(t);
        chk("R6 cleared after rate access", t, 8'h00);
        chk("R10 irq off", irq, 0);
        acc(1'b1, 2'd1, 8'hFF, t);
        peek_stat(t);
        chk("R7 write cannot set", t, 8'h00);

        // R8 collision
        acc(1'b1, 2'd0, 8'h01, t);
        slv_sr = 8'hC3;
        acc(1'b1, 2'd2, 8'h5A, t);
        repeat (5) @(posedge clk);
        acc(1'b1, 2'd2, 8'hFF, t);
        peek_stat(t);
        chk("R8 collision flag", t, 8'h40);
        wait_flag(n);
        chk("R8 length unchanged", n > 0, 1);
        chk("R8 mosi unchanged", mosi_cap, 8'h5A);
        peek_stat(t);
        chk("R5 both flags", t, 8'hC0);
        acc(1'b0, 2'd1, 8'h00, t);
        acc(1'b1, 2'd2, 8'h00, t);
        // R6 clearing write while idle also starts a transfer (R9)
        peek_stat(t);
        chk("R8 both cleared", t, 8'h00);
        slv_sr = 8'h00;
        wait_flag(n);
        acc(1'b0, 2'd1, 8'h00, t);
        acc(1'b0, 2'd2, 8'h00, t);

        for (int i = 0; i < 12; i++) begin
            int r;
            logic [7:0] tx, sl;
            r  = $urandom % 5;
            tx = 8'($urandom);
            sl = 8'($urandom);
            xfer(r, tx, sl, "rnd");
            clear_and_read(sl, "rnd");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule